// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line Break

This block serialises characters onto a single output line that rests high. A host places a byte, plus an optional extra bit, into a one-entry holding register. A shifter then sends the character as a framed sequence: a low start bit, the data bits with the least significant bit first, and a high stop bit. The shifter moves forward one bit for each baud tick. The tick comes from outside and marks one bit time. Any parity is worked out by software and placed in the extra bit, which is sent as the last data bit in nine-bit mode.

Two status outputs let the host pace itself. One says the holding register can accept another character. The other says the line has gone quiet with nothing left to send. A break request replaces data with whole all-low characters for as long as it is held. When the request is dropped, one high bit is sent before any queued data. A transmit enable stops the shifter and parks the line high.

Top module: `uart_brk_tx`

## Requirements
- R1: Each character goes out as one 0 start bit, then the data bits from bit 0 upward, then one 1 stop bit. The line is 1 whenever no character is being sent.
- R2: When `nine_bit_mode` is 0 a character has 8 data bits (10 bit times in all). When it is 1, the `wr_bit8` value written with the byte follows data bit 7 as a ninth data bit (11 bit times in all). The mode is taken when the character enters the shifter.
- R3: `hold_empty` is 1 after reset. It drops the cycle after an accepted write. It rises again the cycle after the held character moves into the shifter, which happens at a bit boundary.
- R4: A character written while another is being sent starts at the tick that ends the stop bit, with no idle bit in between.
- R5: `tx_done` is 1 only when the shifter is idle and the holding register is empty. It falls while a character is waiting or being shifted, and it rises the cycle after the tick that ends the last stop bit.
- R6: A write while `hold_empty` is 0 is ignored. The held character is unchanged and only it is sent.
- R7: While `send_break` is 1, every character started is all zeros with the full length of the current mode. Break characters take precedence over a queued data character.
- R8: After `send_break` is dropped, the break character in progress is completed. Then exactly one 1 bit is sent, and then any queued data.
- R9: While `tx_en` is 0, ticks are ignored and any partly sent character is abandoned. From the next cycle the line is 1. Writes are still accepted and held.
- R10: After reset the line is 1, `hold_empty` is 1 and `tx_done` is 1.
- R11: The line changes only on the clock edge that samples `baud_tick` high, so each bit lasts exactly one tick period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | One-cycle pulse marking the end of a bit time |
| tx_en | input | 1 | Transmit enable; 0 parks the line high |
| nine_bit_mode | input | 1 | 0: 8 data bits, 1: 9 data bits |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Data byte |
| wr_bit8 | input | 1 | Ninth data bit, sent in nine-bit mode |
| send_break | input | 1 | Send all-zero characters while 1 |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register can accept a write |
| tx_done | output | 1 | Line idle and nothing queued |

## Verification
Two events can land on the same tick: the end of one character's stop bit and the start of the next character, which is a data move from the holding register, a break character, or the single high recovery bit. The bench provokes this by writing a second byte as soon as `hold_empty` rises, and by raising and dropping `send_break` while a byte is queued. A cycle-level reference model predicts the line and both flags on every clock. A logger records one line value per tick and checks that the recorded bits join up with no gap, that the zero run is a whole number of characters, and that exactly one high bit comes before the queued data.

// File: rtl/uart_brk_pkg.sv
`timescale 1ns/1ps
package uart_brk_pkg;
  // What the sequencer places into the shifter at a bit boundary
  typedef enum logic [1:0] {
    LD_NONE  = 2'd0,
    LD_DATA  = 2'd1,
    LD_BREAK = 2'd2,
    LD_MARK  = 2'd3
  } load_kind_e;
endpackage

// File: rtl/uart_brk_hold.sv
`timescale 1ns/1ps
module uart_brk_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_xbit,
  input  logic              take,
  output logic              full,
  output logic [DATA_W:0]   data_o
);
  logic            full_q, full_d;
  logic [DATA_W:0] data_q, data_d;
  logic            accept;

  assign accept = wr_valid && !full_q;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (take)   full_d = 1'b0;
    if (accept) begin
      full_d = 1'b1;
      data_d = {wr_xbit, wr_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (accept) data_q <= data_d;
    end
  end

  assign full   = full_q;
  assign data_o = data_q;

  AST_WR_WHILE_FULL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full_q) |=> $stable(data_q)); // R6
  AST_TAKE_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full_q); // R3
endmodule

// File: rtl/uart_brk_shift.sv
`timescale 1ns/1ps
module uart_brk_shift #(
  parameter int FW    = 11,
  parameter int CNT_W = $clog2(FW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             clr,
  input  logic             load,
  input  logic [FW-1:0]    load_frame,
  input  logic [CNT_W-1:0] load_len,
  output logic             txd,
  output logic             busy,
  output logic             boundary
);
  logic [FW-1:0]    sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign busy     = (cnt_q != '0);
  // the current bit ends on this tick with nothing after it
  assign boundary = tick_en && (cnt_q < CNT_W'(2));

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (clr) begin
      sh_d  = '1;
      cnt_d = '0;
    end else if (tick_en) begin
      if (load) begin
        sh_d  = load_frame;
        cnt_d = load_len;
      end else if (busy) begin
        sh_d  = {1'b1, sh_q[FW-1:1]};
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (clr || tick_en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign txd = busy ? sh_q[0] : 1'b1;

  AST_LINE_MOVES_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !clr) |=> $stable(txd)); // R11
  AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> boundary); // R4
  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FW)); // R1
endmodule

// File: rtl/uart_brk_ctrl.sv
`timescale 1ns/1ps
module uart_brk_ctrl
  import uart_brk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FW     = DATA_W + 3,
  parameter int CNT_W  = $clog2(FW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic             clr,
  input  logic             send_break,
  input  logic             nine_bit,
  input  logic             hold_full,
  input  logic [DATA_W:0]  hold_data,
  output logic             load,
  output logic             take,
  output logic [FW-1:0]    frame,
  output logic [CNT_W-1:0] len
);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(FW - 1);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(FW);

  load_kind_e      kind;
  logic            owe_mark_q, owe_mark_d;
  logic [CNT_W-1:0] char_len;
  logic            xbit;

  assign char_len = nine_bit ? LEN_LONG : LEN_SHORT;
  assign xbit     = nine_bit ? hold_data[DATA_W] : 1'b1;

  // pick what starts at this boundary: break beats mark beats data
  always_comb begin
    kind       = LD_NONE;
    owe_mark_d = owe_mark_q;
    if (clr) begin
      owe_mark_d = 1'b0;
    end else if (boundary) begin
      if (send_break) begin
        kind       = LD_BREAK;
        owe_mark_d = 1'b1;
      end else if (owe_mark_q) begin
        kind       = LD_MARK;
        owe_mark_d = 1'b0;
      end else if (hold_full) begin
        kind = LD_DATA;
      end
    end
  end

  always_comb begin
    load  = (kind != LD_NONE);
    take  = (kind == LD_DATA);
    frame = '1;
    len   = char_len;
    case (kind)
      LD_DATA:  frame = {1'b1, xbit, hold_data[DATA_W-1:0], 1'b0};
      LD_BREAK: frame = '0;
      LD_MARK:  len   = CNT_W'(1);
      default:  frame = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owe_mark_q <= 1'b0;
    else        owe_mark_q <= owe_mark_d;
  end

  AST_NO_DATA_WHILE_MARK_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !owe_mark_q); // R8
  AST_BREAK_BLOCKS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    send_break |-> !take); // R7
endmodule

// File: rtl/uart_brk_tx.sv
`timescale 1ns/1ps
module uart_brk_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              nine_bit_mode,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit8,
  input  logic              send_break,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_done
);
  localparam int FW    = DATA_W + 3;
  localparam int CNT_W = $clog2(FW + 1);

  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  logic             tick_en, clr;
  logic             load, take, full, busy, boundary;
  logic [DATA_W:0]  hold_data;
  logic [FW-1:0]    frame;
  logic [CNT_W-1:0] len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  assign tick_en = baud_tick && tx_en;
  assign clr     = !tx_en;

  uart_brk_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n_s), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_xbit(wr_bit8), .take(take), .full(full), .data_o(hold_data)
  );

  uart_brk_ctrl #(.DATA_W(DATA_W), .FW(FW), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .boundary(boundary), .clr(clr),
    .send_break(send_break), .nine_bit(nine_bit_mode), .hold_full(full),
    .hold_data(hold_data), .load(load), .take(take), .frame(frame), .len(len)
  );

  uart_brk_shift #(.FW(FW), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n_s), .tick_en(tick_en), .clr(clr), .load(load),
    .load_frame(frame), .load_len(len), .txd(txd), .busy(busy),
    .boundary(boundary)
  );

  assign hold_empty = !full;
  assign tx_done    = !busy && !full;

  AST_DISABLED_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n_s)
    !tx_en |=> txd); // R9
  AST_EMPTY_AFTER_MOVE: assert property (@(posedge clk) disable iff (!rst_n_s)
    take |=> hold_empty); // R3
  AST_DONE_MEANS_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    tx_done |-> (txd && hold_empty)); // R5
endmodule

// File: tb/test_uart_brk_tx.sv
`timescale 1ns/1ps
module test_uart_brk_tx;
  logic       clk = 1'b0;
  logic       rst_n, baud_tick, tx_en, nine_bit_mode, wr_valid, wr_bit8, send_break;
  logic [7:0] wr_data;
  logic       txd, hold_empty, tx_done;

  int n_checks = 0;
  int n_fail   = 0;
  int tcnt     = 0;

  bit mq[$];       // reference: bits still to go, current bit first
  bit bit_log[$];  // observed: line value at each enabled tick
  bit exp_q[$];
  bit         m_full = 0, m_mark = 0, m_x = 0;
  logic [7:0] m_data = 8'h00;

  always #2.5 clk = ~clk;

  uart_brk_tx i_uart_brk_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .nine_bit_mode(nine_bit_mode), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_bit8(wr_bit8), .send_break(send_break), .txd(txd),
    .hold_empty(hold_empty), .tx_done(tx_done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // reference model, advanced on each clock edge
  always @(posedge clk) begin
    bit old_full;
    if (!rst_n) begin
      mq.delete(); m_full = 0; m_mark = 0;
    end else begin
      old_full = m_full;
      if (tx_en && baud_tick) bit_log.push_back(txd);
      if (!tx_en) begin
        mq.delete(); m_mark = 0;
      end else if (baud_tick) begin
        if (mq.size() > 0) void'(mq.pop_front());
        if (mq.size() == 0) begin
          if (send_break) begin
            for (int i = 0; i < (nine_bit_mode ? 11 : 10); i++) mq.push_back(1'b0);
            m_mark = 1;
          end else if (m_mark) begin
            mq.push_back(1'b1); m_mark = 0;
          end else if (old_full) begin
            mq.push_back(1'b0);
            for (int i = 0; i < 8; i++) mq.push_back(m_data[i]);
            if (nine_bit_mode) mq.push_back(m_x);
            mq.push_back(1'b1);
            m_full = 0;
          end
        end
      end
      if (wr_valid && !old_full) begin
        m_full = 1; m_data = wr_data; m_x = wr_bit8;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    bit ex_txd;
    if (rst_n) begin
      ex_txd = (mq.size() > 0) ? mq[0] : 1'b1;
      check(txd == ex_txd, "R1 R11 line vs model", txd, ex_txd);
      check(hold_empty == !m_full, "R3 hold_empty vs model", hold_empty, !m_full);
      check(tx_done == (mq.size() == 0 && !m_full), "R5 tx_done vs model",
            tx_done, (mq.size() == 0 && !m_full));
    end
  end

  initial begin
    baud_tick = 1'b0;
    forever begin
      @(negedge clk);
      tcnt = (tcnt + 1) % 4;
      baud_tick = (tcnt == 0);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_char(input logic [7:0] d, input bit x);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_bit8 = x;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic push_frame(input logic [7:0] d, input bit nine, input bit x);
    exp_q.push_back(1'b0);
    for (int i = 0; i < 8; i++) exp_q.push_back(d[i]);
    if (nine) exp_q.push_back(x);
    exp_q.push_back(1'b1);
  endtask

  // skip leading idle ones in the log, then compare against exp_q starting at offset
  task automatic check_log(input string tag, input int extra_skip, input bit rest_idle);
    int s = 0, bad = -1;
    while (s < bit_log.size() && bit_log[s] == 1'b1) s++;
    s += extra_skip;
    for (int i = 0; i < exp_q.size(); i++)
      if (bad < 0 && (s + i >= bit_log.size() || bit_log[s + i] != exp_q[i])) bad = i;
    if (bad < 0 && rest_idle)
      for (int i = s + exp_q.size(); i < bit_log.size(); i++)
        if (bad < 0 && bit_log[i] != 1'b1) bad = i - s;
    check(bad < 0, tag, bad, -1);
  endtask

  initial begin
    int z;
    int s;
    rst_n = 1'b0; tx_en = 1'b1; nine_bit_mode = 1'b0; wr_valid = 1'b0;
    wr_data = 8'h00; wr_bit8 = 1'b0; send_break = 1'b0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(4);
    // R10: reset state
    check(txd == 1'b1, "R10 line idle after reset", txd, 1);
    check(hold_empty == 1'b1, "R10 hold_empty after reset", hold_empty, 1);
    check(tx_done == 1'b1, "R10 tx_done after reset", tx_done, 1);

    // R1: plain 8-bit frame
    bit_log.delete(); exp_q.delete();
    write_char(8'h48, 1'b0);
    check(hold_empty == 1'b0, "R3 hold_empty drops after write", hold_empty, 0);
    check(tx_done == 1'b0, "R5 tx_done low with data queued", tx_done, 0);
    wait_cyc(60);
    push_frame(8'h48, 0, 0);
    check_log("R1 8-bit frame bits", 0, 1);
    check(tx_done == 1'b1, "R5 tx_done after stop bit", tx_done, 1);

    // R2: nine-bit frame, extra bit carries software parity
    nine_bit_mode = 1'b1;
    bit_log.delete(); exp_q.delete();
    write_char(8'h3C, 1'b1);
    wait_cyc(60);
    push_frame(8'h3C, 1, 1);
    check_log("R2 9-bit frame bits", 0, 1);
    bit_log.delete(); exp_q.delete();
    write_char(8'hA5, 1'b0);
    wait_cyc(60);
    push_frame(8'hA5, 1, 0);
    check_log("R2 9-bit frame with zero extra bit", 0, 1);
    nine_bit_mode = 1'b0;

    // R4: back-to-back characters, second written as soon as register frees
    bit_log.delete(); exp_q.delete();
    write_char(8'h65, 1'b0);
    for (int i = 0; i < 20 && !hold_empty; i++) @(negedge clk);
    check(hold_empty == 1'b1 && tx_done == 1'b0, "R3 register freed while shifting",
          {hold_empty, tx_done}, 2);
    write_char(8'h21, 1'b0);
    wait_cyc(100);
    push_frame(8'h65, 0, 0);
    push_frame(8'h21, 0, 0);
    check_log("R4 frames with no gap", 0, 1);

    // R6: second write while full is dropped
    bit_log.delete(); exp_q.delete();
    write_char(8'h0F, 1'b0);
    write_char(8'hF0, 1'b0);
    wait_cyc(100);
    push_frame(8'h0F, 0, 0);
    check_log("R6 only first byte sent", 0, 1);
    check(hold_empty == 1'b1, "R6 register empty afterwards", hold_empty, 1);

    // R7 R8: break with a byte queued
    bit_log.delete(); exp_q.delete();
    @(negedge clk); send_break = 1'b1;
    write_char(8'h6C, 1'b0);
    wait_cyc(70);
    check(hold_empty == 1'b0, "R7 data held back during break", hold_empty, 0);
    @(negedge clk); send_break = 1'b0;
    wait_cyc(120);
    s = 0;
    while (s < bit_log.size() && bit_log[s] == 1'b1) s++;
    z = 0;
    while (s + z < bit_log.size() && bit_log[s + z] == 1'b0) z++;
    check(z >= 10 && z % 10 == 0, "R7 break run is whole characters", z, 20);
    check((s + z < bit_log.size()) && bit_log[s + z] == 1'b1, "R8 one mark bit after break",
          (s + z < bit_log.size()) ? bit_log[s + z] : 0, 1);
    push_frame(8'h6C, 0, 0);
    check_log("R8 queued data after single mark", z + 1, 1);

    // R9: disable mid-frame, write while disabled, re-enable
    write_char(8'hC3, 1'b0);
    wait_cyc(20);
    @(negedge clk); tx_en = 1'b0;
    wait_cyc(1);
    check(txd == 1'b1, "R9 line high once disabled", txd, 1);
    write_char(8'h5A, 1'b0);
    wait_cyc(40);
    check(hold_empty == 1'b0, "R9 byte held while disabled", hold_empty, 0);
    check(tx_done == 1'b0, "R9 not done while byte held", tx_done, 0);
    check(txd == 1'b1, "R9 line still high", txd, 1);
    bit_log.delete(); exp_q.delete();
    @(negedge clk); tx_en = 1'b1;
    wait_cyc(60);
    push_frame(8'h5A, 0, 0);
    check_log("R9 held byte sent after enable", 0, 1);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule